// File: doc/BRIEF.md
# Frame Buffer Access Arbiter (Refresh versus Drawing)

This block shares one multiplexed frame buffer bus between two clients: the display refresh engine and the drawing engine. The bus runs fixed memory cycles of two base clocks. In the first clock the block drives the address and raises the address strobe. In the second clock a drawing write drives its data, while a refresh or a drawing read lets the memory drive the bus and captures the word at the end of that clock. The block also drives a half-rate memory-cycle timing output, a read-direction control and a draw/refresh indicator.

A mode input sets who wins a contended slot. In display-first mode a drawing access starts only while horizontal or vertical blanking is flagged, so refresh is never disturbed. In draw-first mode a pending drawing access always takes the next slot. If that slot was also requested for refresh, the refresh is acknowledged as lost and its result is delivered as a blanked word. A memory cycle that has begun always runs to its end, and the winner of the next slot is chosen only at the boundary between cycles.

Top module: `fb_access_arbiter`

## Requirements
- R1: `fb_mcyc_o` alternates every base clock after reset. It is 1 during the address clock and 0 during the data clock of each two-clock memory cycle.
- R2: In the address clock of a granted cycle, `fb_as_o`=1 and `fb_ad_oe_o`=1. `fb_ad_o` carries address bits [DW-1:0] and `fb_hi_o` carries bits [AW-1:DW]. `fb_hi_o` holds its value through the data clock. In an idle slot, `fb_as_o`, `fb_ad_oe_o` and `fb_draw_o` stay 0.
- R3: With `prio_draw_i`=0, a drawing request is granted only at a cycle boundary where `hblank_i` or `vblank_i` is 1. Otherwise a pending refresh request is served and the drawing request waits.
- R4: With `prio_draw_i`=1, a pending drawing request wins the next slot whatever the blanking flags are.
- R5: A refresh cycle pulses `ref_ack_o` in its address clock. It has `fb_draw_o`=0 and `fb_rd_o`=1 in its data clock. One clock after the cycle ends, it pulses `ref_vld_o` with `ref_blank_o`=0 and `ref_data_o` equal to the bus word sampled at the end of the data clock.
- R6: When a drawing access takes a slot while `ref_req_i` is 1, `ref_ack_o`, `ref_lost_o` and `drw_ack_o` pulse together. After that cycle, `ref_vld_o` pulses with `ref_blank_o`=1 and `ref_data_o`=0.
- R7: In a drawing write (`drw_we_i`=1), `fb_draw_o`=1 for the whole cycle. In the data clock, `fb_ad_oe_o`=1, `fb_ad_o`=write data and `fb_rd_o`=0. Data is never driven in the data clock of any other cycle type.
- R8: In a drawing read (`drw_we_i`=0), `fb_rd_o`=1 and `fb_ad_oe_o`=0 in the data clock. One clock after the cycle ends, `drw_rvld_o` pulses for one clock with the captured word on `drw_rdata_o`.
- R9: A request raised during the address clock of a cycle is not granted until the next boundary. The strobe, `fb_hi_o` and `fb_draw_o` of a started cycle are not changed by new requests.
- R10: While `rst` is 1, every strobe, enable, acknowledge and valid output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| prio_draw_i | input | 1 | 1 = drawing first, 0 = display first |
| hblank_i | input | 1 | Horizontal blanking flag |
| vblank_i | input | 1 | Vertical blanking flag |
| ref_req_i | input | 1 | Refresh request, held until acknowledged |
| ref_addr_i | input | AW | Refresh word address |
| drw_req_i | input | 1 | Drawing request, held until acknowledged |
| drw_we_i | input | 1 | 1 = drawing write, 0 = drawing read |
| drw_addr_i | input | AW | Drawing word address |
| drw_wdata_i | input | DW | Drawing write data |
| ref_ack_o | output | 1 | Refresh slot acknowledged (served or lost) |
| ref_lost_o | output | 1 | Refresh slot taken by drawing |
| ref_vld_o | output | 1 | Refresh result valid |
| ref_blank_o | output | 1 | Refresh result is blanked |
| ref_data_o | output | DW | Refresh data |
| drw_ack_o | output | 1 | Drawing access granted |
| drw_rvld_o | output | 1 | Drawing read data valid |
| drw_rdata_o | output | DW | Drawing read data |
| fb_ad_o | output | DW | Multiplexed address/data out |
| fb_ad_oe_o | output | 1 | Drive enable for `fb_ad_o` |
| fb_ad_i | input | DW | Data in from the frame buffer |
| fb_hi_o | output | AW-DW | Upper address bits, held for the whole cycle |
| fb_as_o | output | 1 | Address strobe |
| fb_rd_o | output | 1 | Read direction: memory drives the bus |
| fb_draw_o | output | 1 | 1 = drawing cycle, 0 = refresh or idle |
| fb_mcyc_o | output | 1 | Half-rate memory-cycle timing |

## Verification
The hardest case to reach is a refresh and a drawing request that meet at the same boundary. It has to happen once in draw-first mode during active display, where the refresh must be reported lost and blanked. It has to happen again in display-first mode, where the draw must stay parked until a blanking flag rises. The bench raises both requests at the same falling edge and holds them until their acknowledges. It watches the drawing acknowledge stay low over several slots of active display, and then opens horizontal blanking to release the draw. A second hard case is a request raised exactly in the address clock of an idle slot. The bench lines this up by waiting for the timing output to show the address clock before it raises the request.

// File: rtl/fba_pkg.sv
package fba_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_REF  = 2'd1,
    CYC_DRD  = 2'd2,
    CYC_DWR  = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/fba_phase.sv
// Two-clock memory cycle sequencer: address clock, then data clock.
module fba_phase (
  input  logic clk,
  input  logic rst,
  output logic data_ph_o,   // 1 during the data clock; next edge is a boundary
  output logic mcyc_o
);
  logic ph_q;
  logic mcyc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= 1'b1;       // first edge after reset starts a cycle
      mcyc_q <= 1'b0;
    end else begin
      ph_q   <= ~ph_q;
      mcyc_q <= ph_q;       // high exactly in the address clock
    end
  end

  assign data_ph_o = ph_q;
  assign mcyc_o    = mcyc_q;

  // R1: strict alternation of phases and of the timing output
  a_r1_phase_toggle_hi: assert property (@(posedge clk) disable iff (rst) ph_q |=> !ph_q);
  a_r1_phase_toggle_lo: assert property (@(posedge clk) disable iff (rst) !ph_q |=> ph_q);
  a_r1_mcyc_half_rate:  assert property (@(posedge clk) disable iff (rst) mcyc_q |=> !mcyc_q);
endmodule

// File: rtl/fba_policy.sv
// Slot winner selection at a cycle boundary.
module fba_policy
  import fba_pkg::*;
(
  input  logic      prio_draw_i,
  input  logic      blank_i,
  input  logic      ref_req_i,
  input  logic      drw_req_i,
  input  logic      drw_we_i,
  output cyc_kind_e kind_o,
  output logic      lost_o
);
  logic draw_ok;

  always_comb begin
    draw_ok = drw_req_i && (prio_draw_i || blank_i);
    lost_o  = 1'b0;
    if (draw_ok) begin
      kind_o = drw_we_i ? CYC_DWR : CYC_DRD;
      lost_o = ref_req_i;
    end else if (ref_req_i) begin
      kind_o = CYC_REF;
    end else begin
      kind_o = CYC_IDLE;
    end
  end
endmodule

// File: rtl/fba_engine.sv
// Runs the granted cycle on the bus, registers every output.
module fba_engine
  import fba_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boundary_i,
  input  logic          prio_draw_i,
  input  logic          blank_i,
  input  cyc_kind_e     grant_i,
  input  logic          lost_i,
  input  logic [AW-1:0] ref_addr_i,
  input  logic [AW-1:0] drw_addr_i,
  input  logic [DW-1:0] drw_wdata_i,
  input  logic [DW-1:0] bus_i,
  output logic          ref_ack_o,
  output logic          ref_lost_o,
  output logic          ref_vld_o,
  output logic          ref_blank_o,
  output logic [DW-1:0] ref_data_o,
  output logic          drw_ack_o,
  output logic          drw_rvld_o,
  output logic [DW-1:0] drw_rdata_o,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o,
  output logic [HW-1:0] hi_o,
  output logic          as_o,
  output logic          rd_o,
  output logic          draw_o
);
  cyc_kind_e     kind_q;
  logic          stolen_q;
  logic [DW-1:0] wdata_q;
  logic [AW-1:0] sel_addr;
  logic          grant_draw;
  logic          grant_busy;

  always_comb begin
    sel_addr   = (grant_i == CYC_REF) ? ref_addr_i : drw_addr_i;
    grant_draw = (grant_i == CYC_DRD) || (grant_i == CYC_DWR);
    grant_busy = (grant_i != CYC_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q      <= CYC_IDLE;
      stolen_q    <= 1'b0;
      wdata_q     <= '0;
      ref_ack_o   <= 1'b0;
      ref_lost_o  <= 1'b0;
      ref_vld_o   <= 1'b0;
      ref_blank_o <= 1'b0;
      ref_data_o  <= '0;
      drw_ack_o   <= 1'b0;
      drw_rvld_o  <= 1'b0;
      drw_rdata_o <= '0;
      bus_o       <= '0;
      bus_oe_o    <= 1'b0;
      hi_o        <= '0;
      as_o        <= 1'b0;
      rd_o        <= 1'b0;
      draw_o      <= 1'b0;
    end else begin
      ref_ack_o  <= 1'b0;
      ref_lost_o <= 1'b0;
      ref_vld_o  <= 1'b0;
      drw_ack_o  <= 1'b0;
      drw_rvld_o <= 1'b0;
      if (boundary_i) begin
        // close the finishing cycle
        if (kind_q == CYC_REF) begin
          ref_vld_o   <= 1'b1;
          ref_blank_o <= 1'b0;
          ref_data_o  <= bus_i;
        end
        if (kind_q == CYC_DRD) begin
          drw_rvld_o  <= 1'b1;
          drw_rdata_o <= bus_i;
        end
        if (stolen_q) begin
          ref_vld_o   <= 1'b1;
          ref_blank_o <= 1'b1;
          ref_data_o  <= '0;
        end
        // open the next cycle: address clock
        kind_q     <= grant_i;
        stolen_q   <= lost_i;
        wdata_q    <= drw_wdata_i;
        as_o       <= grant_busy;
        bus_oe_o   <= grant_busy;
        bus_o      <= grant_busy ? sel_addr[DW-1:0] : '0;
        hi_o       <= grant_busy ? sel_addr[AW-1:DW] : '0;
        rd_o       <= 1'b0;
        draw_o     <= grant_draw;
        drw_ack_o  <= grant_draw;
        ref_ack_o  <= (grant_i == CYC_REF) || lost_i;
        ref_lost_o <= lost_i;
      end else begin
        // data clock of the running cycle
        as_o     <= 1'b0;
        bus_oe_o <= (kind_q == CYC_DWR);
        bus_o    <= (kind_q == CYC_DWR) ? wdata_q : '0;
        rd_o     <= (kind_q == CYC_REF) || (kind_q == CYC_DRD);
      end
    end
  end

  // R2: strobe lasts exactly one clock
  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst) as_o |=> !as_o);
  // R9: started cycle keeps its upper address and type
  a_r9_no_abort: assert property (@(posedge clk) disable iff (rst)
    as_o |=> ($stable(hi_o) && $stable(draw_o)));
  // R3: display-first mode keeps drawing out of active display
  a_r3_blank_only: assert property (@(posedge clk) disable iff (rst)
    (boundary_i && !prio_draw_i && !blank_i) |=> !draw_o);
  // R6: a lost refresh always comes with a drawing grant
  a_r6_lost_with_draw: assert property (@(posedge clk) disable iff (rst)
    ref_lost_o |-> (ref_ack_o && drw_ack_o));
  // R7: data-clock drive only for drawing writes
  a_r7_data_drive: assert property (@(posedge clk) disable iff (rst)
    (bus_oe_o && !as_o) |-> (draw_o && !rd_o));
  // R8: no contention while the memory drives
  a_r8_dir_clean: assert property (@(posedge clk) disable iff (rst)
    rd_o |-> (!as_o && !bus_oe_o));
endmodule

// File: rtl/fb_access_arbiter.sv
module fb_access_arbiter
  import fba_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int HW = AW - DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          prio_draw_i,
  input  logic          hblank_i,
  input  logic          vblank_i,
  input  logic          ref_req_i,
  input  logic [AW-1:0] ref_addr_i,
  input  logic          drw_req_i,
  input  logic          drw_we_i,
  input  logic [AW-1:0] drw_addr_i,
  input  logic [DW-1:0] drw_wdata_i,
  output logic          ref_ack_o,
  output logic          ref_lost_o,
  output logic          ref_vld_o,
  output logic          ref_blank_o,
  output logic [DW-1:0] ref_data_o,
  output logic          drw_ack_o,
  output logic          drw_rvld_o,
  output logic [DW-1:0] drw_rdata_o,
  output logic [DW-1:0] fb_ad_o,
  output logic          fb_ad_oe_o,
  input  logic [DW-1:0] fb_ad_i,
  output logic [HW-1:0] fb_hi_o,
  output logic          fb_as_o,
  output logic          fb_rd_o,
  output logic          fb_draw_o,
  output logic          fb_mcyc_o
);
  logic      data_ph;
  logic      blank;
  cyc_kind_e grant;
  logic      lost;

  assign blank = hblank_i | vblank_i;

  fba_phase u_phase (
    .clk       (clk),
    .rst       (rst),
    .data_ph_o (data_ph),
    .mcyc_o    (fb_mcyc_o)
  );

  fba_policy u_policy (
    .prio_draw_i (prio_draw_i),
    .blank_i     (blank),
    .ref_req_i   (ref_req_i),
    .drw_req_i   (drw_req_i),
    .drw_we_i    (drw_we_i),
    .kind_o      (grant),
    .lost_o      (lost)
  );

  fba_engine #(.AW(AW), .DW(DW)) u_engine (
    .clk         (clk),
    .rst         (rst),
    .boundary_i  (data_ph),
    .prio_draw_i (prio_draw_i),
    .blank_i     (blank),
    .grant_i     (grant),
    .lost_i      (lost),
    .ref_addr_i  (ref_addr_i),
    .drw_addr_i  (drw_addr_i),
    .drw_wdata_i (drw_wdata_i),
    .bus_i       (fb_ad_i),
    .ref_ack_o   (ref_ack_o),
    .ref_lost_o  (ref_lost_o),
    .ref_vld_o   (ref_vld_o),
    .ref_blank_o (ref_blank_o),
    .ref_data_o  (ref_data_o),
    .drw_ack_o   (drw_ack_o),
    .drw_rvld_o  (drw_rvld_o),
    .drw_rdata_o (drw_rdata_o),
    .bus_o       (fb_ad_o),
    .bus_oe_o    (fb_ad_oe_o),
    .hi_o        (fb_hi_o),
    .as_o        (fb_as_o),
    .rd_o        (fb_rd_o),
    .draw_o      (fb_draw_o)
  );
endmodule

// File: tb/fb_access_arbiter_bench.sv
module fb_access_arbiter_bench;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int HW = AW - DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic prio_draw = 1'b0, hblank = 1'b0, vblank = 1'b0;
  logic ref_req = 1'b0, drw_req = 1'b0, drw_we = 1'b0;
  logic [AW-1:0] ref_addr = '0, drw_addr = '0;
  logic [DW-1:0] drw_wdata = '0, fb_ad_i = '0;
  logic ref_ack, ref_lost, ref_vld, ref_blank, drw_ack, drw_rvld;
  logic [DW-1:0] ref_data, drw_rdata, fb_ad_o;
  logic fb_ad_oe, fb_as, fb_rd, fb_draw, fb_mcyc;
  logic [HW-1:0] fb_hi;

  fb_access_arbiter #(.AW(AW), .DW(DW)) u_fb_access_arbiter (
    .clk(clk), .rst(rst), .prio_draw_i(prio_draw), .hblank_i(hblank), .vblank_i(vblank),
    .ref_req_i(ref_req), .ref_addr_i(ref_addr), .drw_req_i(drw_req), .drw_we_i(drw_we),
    .drw_addr_i(drw_addr), .drw_wdata_i(drw_wdata), .ref_ack_o(ref_ack), .ref_lost_o(ref_lost),
    .ref_vld_o(ref_vld), .ref_blank_o(ref_blank), .ref_data_o(ref_data), .drw_ack_o(drw_ack),
    .drw_rvld_o(drw_rvld), .drw_rdata_o(drw_rdata), .fb_ad_o(fb_ad_o), .fb_ad_oe_o(fb_ad_oe),
    .fb_ad_i(fb_ad_i), .fb_hi_o(fb_hi), .fb_as_o(fb_as), .fb_rd_o(fb_rd), .fb_draw_o(fb_draw),
    .fb_mcyc_o(fb_mcyc)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model with a computed initial pattern
  logic [DW-1:0] mem [256];
  logic [AW-1:0] lat_addr = '0;
  initial for (int i = 0; i < 256; i++) mem[i] = 16'(i * 257) ^ 16'h5A00;

  always @(negedge clk) begin
    if (fb_as) lat_addr = {fb_hi, fb_ad_o};
    if (fb_rd) fb_ad_i <= mem[lat_addr[7:0]];
    else       fb_ad_i <= '0;
    if (fb_ad_oe && !fb_as && fb_draw) mem[lat_addr[7:0]] = fb_ad_o;
  end

  // scoreboard: {blank, data} for refresh, data for drawing reads
  logic [DW:0]   ref_q [$];
  logic [DW-1:0] drd_q [$];

  always @(negedge clk) begin
    if (!rst && ref_vld) begin
      if (ref_q.size() == 0) chk(1'b0, "R5 unexpected refresh result", 32'(ref_data), 32'hFFFF);
      else begin
        logic [DW:0] e;
        e = ref_q.pop_front();
        chk({ref_blank, ref_data} == e, e[DW] ? "R6 blanked result" : "R5 refresh data",
            32'({ref_blank, ref_data}), 32'(e));
      end
    end
    if (!rst && drw_rvld) begin
      if (drd_q.size() == 0) chk(1'b0, "R8 unexpected read result", 32'(drw_rdata), 32'hFFFF);
      else begin
        logic [DW-1:0] e;
        e = drd_q.pop_front();
        chk(drw_rdata == e, "R8 draw read data", 32'(drw_rdata), 32'(e));
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!fb_as && !fb_ad_oe && !fb_rd && !fb_draw, "R10 bus idle in reset",
        32'({fb_as, fb_ad_oe, fb_rd, fb_draw}), 0);
    chk(!ref_ack && !drw_ack && !ref_vld && !drw_rvld && !ref_lost, "R10 handshakes low in reset",
        32'({ref_ack, drw_ack, ref_vld, drw_rvld, ref_lost}), 0);
    rst = 1'b0;

    // R1 timing output alternation
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(fb_mcyc == ((i % 2) == 0), "R1 mcyc alternation", 32'(fb_mcyc), 32'((i % 2) == 0));
    end
    chk(!fb_as && !fb_draw, "R2 idle slot no strobe", 32'({fb_as, fb_draw}), 0);

    // R9 + R2 + R5: request raised in the address clock of an idle slot
    while (!fb_mcyc) @(negedge clk);
    ref_req  = 1'b1;
    ref_addr = 20'hA0055;
    ref_q.push_back({1'b0, mem[8'h55]});
    @(negedge clk);
    chk(!ref_ack && !fb_as, "R9 no grant mid-cycle", 32'({ref_ack, fb_as}), 0);
    @(negedge clk);
    chk(ref_ack && fb_as && fb_ad_oe, "R9 grant at boundary", 32'({ref_ack, fb_as, fb_ad_oe}), 3'b111);
    chk({fb_hi, fb_ad_o} == 20'hA0055, "R2 address phase", 32'({fb_hi, fb_ad_o}), 32'h000A0055);
    chk(!fb_draw, "R5 refresh not draw", 32'(fb_draw), 0);
    ref_req = 1'b0;
    @(negedge clk);
    chk(fb_rd && !fb_as && !fb_ad_oe && fb_hi == 4'hA, "R5 read direction, R2 hi held",
        32'({fb_rd, fb_as, fb_ad_oe, fb_hi}), 32'({3'b100, 4'hA}));
    repeat (4) @(negedge clk);

    // R3: display-first, active display, both requests: refresh wins
    prio_draw = 1'b0;
    ref_req = 1'b1; ref_addr = 20'h00040;
    drw_req = 1'b1; drw_we = 1'b1; drw_addr = 20'h00041; drw_wdata = 16'h1234;
    ref_q.push_back({1'b0, mem[8'h40]});
    do @(negedge clk); while (!ref_ack);
    chk(!ref_lost && !drw_ack, "R3 refresh kept in active display", 32'({ref_lost, drw_ack}), 0);
    ref_req = 1'b0;
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (drw_ack || fb_draw) seen = 1'b1;
      end
      chk(!seen, "R3 draw parked outside blanking", 32'(seen), 0);
    end
    hblank = 1'b1;
    do @(negedge clk); while (!drw_ack);
    chk(fb_as && fb_draw && fb_ad_o == 16'h0041, "R3 draw in blanking address",
        32'({fb_as, fb_draw, fb_ad_o}), 32'({2'b11, 16'h0041}));
    drw_req = 1'b0;
    @(negedge clk);
    chk(fb_ad_oe && fb_ad_o == 16'h1234 && !fb_rd && fb_draw && !fb_as, "R7 write data phase",
        32'({fb_ad_oe, fb_rd, fb_draw, fb_ad_o}), 32'({3'b101, 16'h1234}));
    hblank = 1'b0;
    repeat (3) @(negedge clk);

    // R8: read back in vertical blanking
    vblank = 1'b1;
    drw_req = 1'b1; drw_we = 1'b0; drw_addr = 20'h00041;
    drd_q.push_back(16'h1234);
    do @(negedge clk); while (!drw_ack);
    drw_req = 1'b0;
    @(negedge clk);
    chk(fb_rd && !fb_ad_oe && fb_draw, "R8 read data phase", 32'({fb_rd, fb_ad_oe, fb_draw}), 3'b101);
    vblank = 1'b0;
    repeat (4) @(negedge clk);

    // R4 + R6: draw-first, active display, both requests
    prio_draw = 1'b1;
    ref_req = 1'b1; ref_addr = 20'h00033;
    drw_req = 1'b1; drw_we = 1'b0; drw_addr = 20'h00041;
    ref_q.push_back({1'b1, 16'h0000});
    drd_q.push_back(16'h1234);
    do @(negedge clk); while (!drw_ack);
    chk(ref_ack && ref_lost, "R6 refresh lost with draw grant", 32'({ref_ack, ref_lost}), 2'b11);
    chk(fb_as && fb_draw, "R4 draw wins active slot", 32'({fb_as, fb_draw}), 2'b11);
    ref_req = 1'b0; drw_req = 1'b0;
    repeat (6) @(negedge clk);

    // R4: draw-first write during active display, then read by refresh
    drw_req = 1'b1; drw_we = 1'b1; drw_addr = 20'h00077; drw_wdata = 16'hBEEF;
    do @(negedge clk); while (!drw_ack);
    drw_req = 1'b0;
    ref_req = 1'b1; ref_addr = 20'h00077;
    ref_q.push_back({1'b0, 16'hBEEF});
    do @(negedge clk); while (!ref_ack);
    chk(!ref_lost, "R5 refresh served after write", 32'(ref_lost), 0);
    ref_req = 1'b0;
    repeat (6) @(negedge clk);

    chk(ref_q.size() == 0, "R5 all refresh results seen", 32'(ref_q.size()), 0);
    chk(drd_q.size() == 0, "R8 all read results seen", 32'(drd_q.size()), 0);
    done = 1'b1;
    summary();
  end
endmodule